// File: doc/BRIEF.md
# Non-Cacheable Window Filter

This block sits in front of a flash cache and rules, for every flash access, whether the access may be placed in the cache. Software programs a small control word and up to two address windows through a narrow register write port. Each window has a lower and an upper bound kept at 16-byte granularity and its own enable. An access whose address lands inside any enabled window is kept out of the cache. Outside the windows, the access is cached only when the global enable is on and the enable for its kind of access (instruction fetch or data read) is on.

A lookup is presented with a one-cycle strobe, the address and a flag for the access kind. The verdict comes back registered one clock later. All state clears on reset, so nothing is cached until software turns caching on.

Top module: `nc_region_filter`

## Requirements
- R1: After reset `dec_valid` and `dec_cacheable` are 0 and all stored state is zero, so every lookup is judged non-cacheable until the control word is written.
- R2: `dec_valid` is 1 in exactly the cycle after a cycle with `lkp_valid` high. When `dec_valid` is 0, `dec_cacheable` is also 0.
- R3: When control bit 0 (global enable) is 0, every lookup returns non-cacheable.
- R4: With `lkp_is_data` = 0 (instruction fetch) an access can be cacheable only when control bit 8 is 1. With `lkp_is_data` = 1 (data read) it can be cacheable only when control bit 9 is 1.
- R5: An address is inside a window when its bits 19:4 are at least the stored lower bound and at most the stored upper bound. Both ends are inclusive.
- R6: Window 0 takes part only when control bit 2 is 1, and window 1 only when control bit 3 is 1. Each window is enabled on its own.
- R7: An address inside any enabled window is non-cacheable, even when the enables of R3 and R4 would allow caching.
- R8: A window whose upper bound is below its lower bound contains no address.
- R9: A bound write keeps only bits 19:4 of the write data. The low four bits of a written bound and of a lookup address have no effect on the verdict.
- R10: The register selects are: 0 for the control word, 1 for the window 0 lower bound, 2 for the window 0 upper bound, 3 for the window 1 lower bound and 4 for the window 1 upper bound. Writes with any other select change nothing. A lookup in the same cycle as a write is judged with the values held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 3 | Register select (see R10) |
| cfg_wr_data | input | 32 | Write data |
| lkp_valid | input | 1 | Lookup strobe |
| lkp_is_data | input | 1 | 1 = data read, 0 = instruction fetch |
| lkp_addr | input | 20 | Lookup byte address |
| dec_valid | output | 1 | Verdict valid, one cycle after the strobe |
| dec_cacheable | output | 1 | 1 = the access may be cached |

## Verification
The bench builds the block with its default parameters: two windows, a 20-bit address, 16-byte granularity and a 32-bit write bus. With these values every select code, including the three unused ones, can be reached. The windows can also be placed so that they overlap, sit next to each other or are inverted. The directed part walks each window edge one granule inside and one granule outside, and it feeds in write data and addresses whose low bits are nonzero. A long pseudo-random phase then mixes writes and lookups, including writes that land in the same cycle as a lookup.

// File: rtl/ncf_pkg.sv
package ncf_pkg;

   // Control word field positions; software and the decision logic agree on these.
   localparam int CTL_MAIN    = 0;
   localparam int CTL_WIN_LSB = 2;
   localparam int CTL_INSN    = 8;
   localparam int CTL_DATA    = 9;

   typedef enum logic {
      ACC_INSN = 1'b0,
      ACC_DATA = 1'b1
   } acc_kind_e;

   // Select code of the control word; window w uses 1+2w (lower) and 2+2w (upper).
   localparam int SEL_CTRL = 0;

endpackage

// File: rtl/ncf_cfg_regs.sv
module ncf_cfg_regs
   import ncf_pkg::*;
#(
   parameter int NUM_WIN  = 2,
   parameter int ADDR_W   = 20,
   parameter int GRAN_LSB = 4,
   parameter int DATA_W   = 32,
   parameter int SEL_W    = 3,
   localparam int BND_W   = ADDR_W - GRAN_LSB
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [SEL_W-1:0]                wr_sel,
   input  logic [DATA_W-1:0]               wr_data,
   output logic                            en_main,
   output logic                            en_insn,
   output logic                            en_data,
   output logic [NUM_WIN-1:0]              win_en,
   output logic [NUM_WIN-1:0][BND_W-1:0]   win_lo,
   output logic [NUM_WIN-1:0][BND_W-1:0]   win_hi
);

   localparam logic [SEL_W-1:0] LAST_CODE = SEL_W'(2 * NUM_WIN);

   logic unused_wr_bits;
   assign unused_wr_bits = ^wr_data;

   logic ctrl_we;
   assign ctrl_we = wr_en && (wr_sel == SEL_W'(SEL_CTRL));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_main <= 1'b0;
         en_insn <= 1'b0;
         en_data <= 1'b0;
         win_en  <= '0;
      end else if (ctrl_we) begin
         en_main <= wr_data[CTL_MAIN];
         en_insn <= wr_data[CTL_INSN];
         en_data <= wr_data[CTL_DATA];
         win_en  <= wr_data[CTL_WIN_LSB +: NUM_WIN];
      end
   end

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      localparam logic [SEL_W-1:0] LO_CODE = SEL_W'(1 + 2 * w);
      localparam logic [SEL_W-1:0] HI_CODE = SEL_W'(2 + 2 * w);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            win_lo[w] <= '0;
            win_hi[w] <= '0;
         end else if (wr_en) begin
            if (wr_sel == LO_CODE) win_lo[w] <= wr_data[ADDR_W-1:GRAN_LSB];
            if (wr_sel == HI_CODE) win_hi[w] <= wr_data[ADDR_W-1:GRAN_LSB];
         end
      end
   end

   // R10: unused select codes leave every stored value untouched
   p_stray_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_sel > LAST_CODE)) |=>
         ($stable(win_lo) && $stable(win_hi) && $stable(win_en) &&
          $stable(en_main) && $stable(en_insn) && $stable(en_data)));

endmodule

// File: rtl/ncf_window_cmp.sv
module ncf_window_cmp #(
   parameter int ADDR_W   = 20,
   parameter int GRAN_LSB = 4,
   localparam int BND_W   = ADDR_W - GRAN_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [BND_W-1:0]  lo,
   input  logic [BND_W-1:0]  hi,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);

   // Bounds widened to byte addresses: lower edge at the first byte of its
   // granule, upper edge at the last byte, so the address low bits never matter.
   logic [ADDR_W-1:0] lo_byte, hi_byte;
   assign lo_byte = {lo, {GRAN_LSB{1'b0}}};
   assign hi_byte = {hi, {GRAN_LSB{1'b1}}};

   logic above_lo, below_hi;
   assign above_lo = (addr >= lo_byte);
   assign below_hi = (addr <= hi_byte);
   assign hit      = enable && above_lo && below_hi;

   // R8: an inverted window matches nothing
   p_inverted_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (hi < lo) |-> !hit);

endmodule

// File: rtl/nc_region_filter.sv
module nc_region_filter
   import ncf_pkg::*;
#(
   parameter int NUM_WIN  = 2,
   parameter int ADDR_W   = 20,
   parameter int GRAN_LSB = 4,
   parameter int DATA_W   = 32,
   localparam int SEL_W   = $clog2(2 * NUM_WIN + 1),
   localparam int BND_W   = ADDR_W - GRAN_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic [SEL_W-1:0]  cfg_wr_sel,
   input  logic [DATA_W-1:0] cfg_wr_data,
   input  logic              lkp_valid,
   input  logic              lkp_is_data,
   input  logic [ADDR_W-1:0] lkp_addr,
   output logic              dec_valid,
   output logic              dec_cacheable
);

   if (NUM_WIN < 1 || CTL_WIN_LSB + NUM_WIN > CTL_INSN) begin : g_bad_win
      $error("NUM_WIN must leave the window enables below the access-kind enables");
   end
   if (GRAN_LSB < 0 || GRAN_LSB >= ADDR_W) begin : g_bad_gran
      $error("GRAN_LSB must lie inside the address");
   end
   if (DATA_W < ADDR_W || DATA_W <= CTL_DATA) begin : g_bad_data
      $error("DATA_W too narrow for bounds or control fields");
   end

   logic                           en_main, en_insn, en_data;
   logic [NUM_WIN-1:0]             win_en;
   logic [NUM_WIN-1:0][BND_W-1:0]  win_lo, win_hi;
   logic [NUM_WIN-1:0]             win_hit;

   ncf_cfg_regs #(
      .NUM_WIN (NUM_WIN),
      .ADDR_W  (ADDR_W),
      .GRAN_LSB(GRAN_LSB),
      .DATA_W  (DATA_W),
      .SEL_W   (SEL_W)
   ) i_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_wr_en),
      .wr_sel (cfg_wr_sel),
      .wr_data(cfg_wr_data),
      .en_main(en_main),
      .en_insn(en_insn),
      .en_data(en_data),
      .win_en (win_en),
      .win_lo (win_lo),
      .win_hi (win_hi)
   );

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
      ncf_window_cmp #(
         .ADDR_W  (ADDR_W),
         .GRAN_LSB(GRAN_LSB)
      ) i_cmp (
         .clk   (clk),
         .rst_n (rst_n),
         .enable(win_en[w]),
         .lo    (win_lo[w]),
         .hi    (win_hi[w]),
         .addr  (lkp_addr),
         .hit   (win_hit[w])
      );
   end

   acc_kind_e kind;
   logic      kind_on, allow;
   assign kind    = acc_kind_e'(lkp_is_data);
   assign kind_on = (kind == ACC_DATA) ? en_data : en_insn;
   assign allow   = en_main && kind_on && !(|win_hit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_valid     <= 1'b0;
         dec_cacheable <= 1'b0;
      end else begin
         dec_valid     <= lkp_valid;
         dec_cacheable <= lkp_valid && allow;
      end
   end

   // R2: verdict one cycle after the strobe, quiet otherwise
   p_dec_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      lkp_valid |=> dec_valid);
   p_dec_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !lkp_valid |=> (!dec_valid && !dec_cacheable));
   // R3: global enable gates everything
   p_main_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (lkp_valid && !en_main) |=> !dec_cacheable);
   // R4: per-kind enable gates its own accesses
   p_kind_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (lkp_valid && !kind_on) |=> !dec_cacheable);
   // R7: a window hit overrides every enable
   p_window_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (lkp_valid && (|win_hit)) |=> !dec_cacheable);

endmodule

// File: tb/test_nc_region_filter.sv
module test_nc_region_filter;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [2:0]  cfg_wr_sel = '0;
   logic [31:0] cfg_wr_data = '0;
   logic        lkp_valid = 1'b0;
   logic        lkp_is_data = 1'b0;
   logic [19:0] lkp_addr = '0;
   logic        dec_valid, dec_cacheable;

   always #(CLK_PERIOD / 2) clk = ~clk;

   nc_region_filter i_nc_region_filter (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_wr_en    (cfg_wr_en),
      .cfg_wr_sel   (cfg_wr_sel),
      .cfg_wr_data  (cfg_wr_data),
      .lkp_valid    (lkp_valid),
      .lkp_is_data  (lkp_is_data),
      .lkp_addr     (lkp_addr),
      .dec_valid    (dec_valid),
      .dec_cacheable(dec_cacheable)
   );

   int vectors = 0;
   int miscompares = 0;

   // behavioural model state
   bit          m_main, m_insn, m_data;
   bit [1:0]    m_wen;
   int unsigned m_lo[2];
   int unsigned m_hi[2];

   function automatic bit model_hit(logic [19:0] a);
      int unsigned g = int'(a) >> 4;
      for (int w = 0; w < 2; w++)
         if (m_wen[w] && g >= m_lo[w] && g <= m_hi[w]) return 1'b1;
      return 1'b0;
   endfunction

   function automatic bit model_allow(bit isd, logic [19:0] a);
      bit kind_on = isd ? m_data : m_insn;
      return m_main && kind_on && !model_hit(a);
   endfunction

   task automatic model_write(int sel, logic [31:0] d);
      case (sel)
         0: begin m_main = d[0]; m_wen = d[3:2]; m_insn = d[8]; m_data = d[9]; end
         1: m_lo[0] = int'(d[19:4]);
         2: m_hi[0] = int'(d[19:4]);
         3: m_lo[1] = int'(d[19:4]);
         4: m_hi[1] = int'(d[19:4]);
         default: ;
      endcase
   endtask

   task automatic check(string tag, bit ev, bit ec);
      vectors++;
      if (dec_valid !== ev || dec_cacheable !== ec) begin
         miscompares++;
         $display("FAIL %s: valid/cacheable got %b/%b expected %b/%b",
                  tag, dec_valid, dec_cacheable, ev, ec);
      end
   endtask

   // One cycle: drive at the falling edge, predict, update model, compare at next falling edge.
   task automatic step(bit we, int sel, logic [31:0] wd, bit lv, bit isd,
                       logic [19:0] a, string tag);
      bit    ev, ec;
      string t = tag;
      cfg_wr_en   = we;
      cfg_wr_sel  = 3'(sel);
      cfg_wr_data = wd;
      lkp_valid   = lv;
      lkp_is_data = isd;
      lkp_addr    = a;
      ev = lv;
      ec = lv && model_allow(isd, a);
      if (t == "") begin
         if (!lv)                t = "R2";
         else if (!m_main)       t = "R3";
         else if (model_hit(a))  t = "R7";
         else                    t = "R4";
      end
      if (we) model_write(sel, wd);
      @(posedge clk);
      @(negedge clk);
      check(t, ev, ec);
   endtask

   task automatic wr(int sel, logic [31:0] d);
      step(1'b1, sel, d, 1'b0, 1'b0, 20'h0, "R2");
   endtask

   task automatic look(bit isd, logic [19:0] a, string tag);
      step(1'b0, 0, 32'h0, 1'b1, isd, a, tag);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: run did not finish, got hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      bit [31:0] seed = 32'h1234_5678;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      check("R1", 1'b0, 1'b0);
      look(1'b0, 20'h00100, "R1");
      look(1'b1, 20'h00100, "R1");

      // R4: per-kind enables
      wr(0, 32'h0000_0101);
      look(1'b0, 20'h04440, "R4");
      look(1'b1, 20'h04440, "R4");
      wr(0, 32'h0000_0301);
      look(1'b1, 20'h04440, "R4");
      // R3: global enable off
      wr(0, 32'h0000_0300);
      look(1'b0, 20'h04440, "R3");
      look(1'b1, 20'h04440, "R3");

      // R9: low bits of written bounds ignored; window 0 = granules 0x0123..0x0125
      wr(1, 32'hFFF0_1237);
      wr(2, 32'h0000_125A);
      wr(0, 32'h0000_0305);
      // R5: inclusive edges
      look(1'b0, 20'h0122F, "R5");
      look(1'b0, 20'h01230, "R5");
      look(1'b0, 20'h0125F, "R5");
      look(1'b0, 20'h01260, "R5");
      look(1'b0, 20'h0123C, "R9");
      // R7: hit overrides data enable too
      look(1'b1, 20'h01240, "R7");

      // R6: window 1 only counts when its own bit is set
      wr(3, 32'h0000_2000);
      wr(4, 32'h0000_2FFF);
      look(1'b0, 20'h02500, "R6");
      wr(0, 32'h0000_030D);
      look(1'b0, 20'h02500, "R6");
      wr(0, 32'h0000_0309);
      look(1'b0, 20'h01240, "R6");
      look(1'b1, 20'h02FFF, "R6");

      // R8: inverted window 1
      wr(3, 32'h0000_3000);
      wr(4, 32'h0000_2000);
      look(1'b0, 20'h02800, "R8");
      look(1'b0, 20'h03000, "R8");
      look(1'b0, 20'h02000, "R8");

      // R10: stray selects change nothing
      step(1'b1, 5, 32'hFFFF_FFFF, 1'b1, 1'b0, 20'h02800, "R10");
      step(1'b1, 6, 32'h0000_0000, 1'b1, 1'b1, 20'h02800, "R10");
      step(1'b1, 7, 32'h0000_0000, 1'b1, 1'b0, 20'h01240, "R10");
      look(1'b0, 20'h02800, "R10");
      // R10: same-cycle write judged with old values, new values next cycle
      step(1'b1, 0, 32'h0000_0000, 1'b1, 1'b0, 20'h02800, "R10");
      look(1'b0, 20'h02800, "R10");
      step(1'b0, 0, 32'h0, 1'b0, 1'b0, 20'h0, "R2");

      // mixed pseudo-random traffic
      for (int i = 0; i < 4000; i++) begin
         bit        we, lv, isd;
         int        sel;
         logic [31:0] d;
         logic [19:0] a;
         seed = seed * 32'd1103515245 + 32'd12345;
         we  = (seed[30:28] == 3'd0);
         sel = int'(seed[27:25]);
         lv  = (seed[24:23] != 2'd0);
         isd = seed[22];
         seed = seed * 32'd1103515245 + 32'd12345;
         d = seed ^ {seed[15:0], seed[31:16]};
         if (sel == 0) d[0] = d[0] | seed[5];
         seed = seed * 32'd1103515245 + 32'd12345;
         a = seed[27:8];
         step(we, sel, d, lv, isd, a, "");
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule